// File: doc/BRIEF.md
# Register-Machine ALU Execute Stage

This block is the execute stage of a 64-bit register machine with eleven general registers. Each cycle it can accept one decoded arithmetic instruction: an 8-bit opcode, a destination index, a source index and a 32-bit immediate. It reads the operands from its own register file and computes the result. At the next rising clock edge it writes the result back to the destination register. Register r10 is an ordinary register that software also uses as the frame pointer.

Every operation comes in two width classes, chosen by the low three opcode bits, and in two operand forms, chosen by opcode bit 3. The 64-bit class works on full registers and sign-extends the immediate. The 32-bit class works on the low halves as unsigned values and writes its result zero-extended. The negate encoding with the register-source bit set is repurposed: in the 32-bit class it is a breakpoint that raises a trap flag and leaves every register untouched. Any other undefined encoding raises an illegal-instruction flag instead of writing.

A read-only peek port shows any register to the surrounding pipeline or to a bench. Fetch, branching, memory access and byte swapping belong to other blocks.

Top module: `vm_alu_stage`

## Requirements
- R1: A synchronous active-low reset clears all eleven registers to zero and drives trap_o and illegal_o low.
- R2: Opcode fields: bits [2:0] select the class (4 = 32-bit, 7 = 64-bit), bit 3 selects the second operand (0 = imm32, 1 = source register), and bits [7:4] select the operation: 0 add, 1 sub, 2 mul, 3 unsigned div, 4 or, 5 and, 6 left shift, 7 logical right shift, 8 negate, 9 unsigned mod, 10 xor, 11 move, 12 arithmetic right shift.
- R3: A 64-bit-class instruction computes dst = dst OP operand over all 64 bits, and imm32 is sign-extended to 64 bits first.
- R4: A 32-bit-class instruction operates on the low 32 bits of dst and of the operand as unsigned values and writes the result zero-extended (bits [63:32] = 0).
- R5: Shift amounts use only the low 6 bits of the operand in the 64-bit class and the low 5 bits in the 32-bit class; arithmetic right shift fills with the sign bit of the operating width.
- R6: Move copies the operand into dst with no arithmetic: 0xb7 (64-bit, imm), 0xbf (64-bit, register), 0xb4 (32-bit, imm), 0xbc (32-bit, register).
- R7: Negate (0x87 64-bit, 0x84 32-bit) is unary: dst = 0 - dst, and it ignores the source index and the immediate.
- R8: Division by zero writes 0 to dst; modulo by zero writes nothing, so dst keeps its full 64-bit value.
- R9: Opcode 0x8c is a breakpoint. It writes no register, and trap_o is high for exactly the one cycle that follows the issue cycle.
- R10: These encodings are illegal: a class other than 4 or 7, an operation code of 13 to 15, opcode 0x8f, a destination index above 10, or a register-form source index above 10. An illegal instruction writes nothing, and illegal_o is high for the one cycle that follows.
- R11: The result is written at the clock edge that ends the issue cycle, so an instruction issued in the very next cycle reads the new value.
- R12: While issue_valid is low, no register changes and both flags stay low, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | An instruction is presented this cycle |
| opcode | input | 8 | Decoded opcode byte |
| dst_sel | input | 4 | Destination register index |
| src_sel | input | 4 | Source register index |
| imm32 | input | 32 | Immediate operand |
| peek_sel | input | 4 | Register index for the peek port |
| peek_data | output | 64 | Current value of the peeked register (0 for an index above 10) |
| trap_o | output | 1 | Breakpoint seen in the previous cycle |
| illegal_o | output | 1 | Illegal instruction seen in the previous cycle |

## Verification
Two things can happen in the same cycle: the write-back of one instruction and the operand read of the next, and also a breakpoint's trap flag together with the write of the instruction that follows it. The bench provokes both by issuing a dependent chain on consecutive cycles with no idle slot, and by placing a breakpoint between two writes. It judges the chain by the final register values, which are correct only if every link saw its predecessor's result. It judges the breakpoint case by seeing trap_o high in the exact cycle in which the following write is being issued, while the register that the breakpoint names stays unchanged.

// File: rtl/vm_alu_pkg.sv
// Shared types for the ALU execute stage.
// Assumes a 4-bit operation field in opcode bits [7:4].
package vm_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_SUB  = 4'h1,
        OP_MUL  = 4'h2,
        OP_DIV  = 4'h3,
        OP_OR   = 4'h4,
        OP_AND  = 4'h5,
        OP_LSH  = 4'h6,
        OP_RSH  = 4'h7,
        OP_NEG  = 4'h8,
        OP_MOD  = 4'h9,
        OP_XOR  = 4'ha,
        OP_MOV  = 4'hb,
        OP_ARSH = 4'hc
    } alu_op_e;

    localparam logic [2:0] CLS_W32 = 3'h4;
    localparam logic [2:0] CLS_W64 = 3'h7;
    localparam logic [3:0] OP_LAST = 4'hc;

    typedef struct packed {
        logic    wr_ok;
        logic    trap;
        logic    illegal;
        logic    is32;
        logic    use_reg;
        alu_op_e op;
    } dec_s;

endpackage

// File: rtl/vm_regfile.sv
// Register file: NREGS registers of XLEN bits with one synchronous write
// port and three combinational read ports (two operands, one peek).
// Assumes the write index is already range-checked by the decoder;
// an out-of-range read returns zero.
module vm_regfile #(
    parameter int XLEN  = 64,
    parameter int NREGS = 11,
    parameter int IDXW  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [IDXW-1:0] wa,
    input  logic [XLEN-1:0] wd,
    input  logic [IDXW-1:0] ra_a,
    output logic [XLEN-1:0] rd_a,
    input  logic [IDXW-1:0] ra_b,
    output logic [XLEN-1:0] rd_b,
    input  logic [IDXW-1:0] ra_p,
    output logic [XLEN-1:0] rd_p
);
    localparam logic [IDXW-1:0] LAST = IDXW'(NREGS - 1);

    logic [XLEN-1:0] regs [NREGS];

    // Bounded read of one register.
    function automatic logic [XLEN-1:0] rd(input logic [IDXW-1:0] idx);
        return (idx <= LAST) ? regs[idx] : '0;
    endfunction

    // Clear all registers on reset, otherwise perform the single write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we && (wa <= LAST)) begin
            regs[wa] <= wd;
        end
    end

    // Combinational read ports.
    always_comb begin
        rd_a = rd(ra_a);
        rd_b = rd(ra_b);
        rd_p = rd(ra_p);
    end
endmodule

// File: rtl/vm_op_decode.sv
// Opcode decoder: splits the opcode into class, operand form and operation,
// and classifies the instruction as writable, breakpoint or illegal.
// Assumes the breakpoint ignores its register indices.
module vm_op_decode
    import vm_alu_pkg::*;
#(
    parameter int NREGS = 11,
    parameter int IDXW  = 4
) (
    input  logic            valid,
    input  logic [7:0]      opcode,
    input  logic [IDXW-1:0] dst_sel,
    input  logic [IDXW-1:0] src_sel,
    output dec_s            dec
);
    localparam logic [IDXW-1:0] LAST = IDXW'(NREGS - 1);

    logic [2:0] cls;
    logic [3:0] opf;
    logic       brk;
    logic       ok;

    // Field split and legality classification.
    always_comb begin
        cls         = opcode[2:0];
        opf         = opcode[7:4];
        dec         = '0;
        dec.is32    = (cls == CLS_W32);
        dec.use_reg = opcode[3];
        dec.op      = alu_op_e'(opf);
        brk = dec.is32 && dec.use_reg && (opf == OP_NEG);
        ok  = ((cls == CLS_W32) || (cls == CLS_W64))
              && (opf <= OP_LAST)
              && !(dec.use_reg && (opf == OP_NEG))
              && (dst_sel <= LAST)
              && (!dec.use_reg || (src_sel <= LAST));
        dec.trap    = valid && brk;
        dec.illegal = valid && !brk && !ok;
        dec.wr_ok   = valid && ok;
    end
endmodule

// File: rtl/vm_alu_lane.sv
// One ALU lane of width W. Shift amounts are the low clog2(W) bits of b.
// hold is raised for modulo by zero so that the caller skips the write.
module vm_alu_lane
    import vm_alu_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] res,
    output logic         hold
);
    localparam int SHW = $clog2(W);

    logic [SHW-1:0] sh;
    logic           b_zero;

    assign sh     = b[SHW-1:0];
    assign b_zero = (b == '0);

    // Operation select for this width.
    always_comb begin
        res  = a;
        hold = 1'b0;
        case (op)
            OP_ADD:  res = a + b;
            OP_SUB:  res = a - b;
            OP_MUL:  res = a * b;
            OP_DIV:  res = b_zero ? '0 : a / b;
            OP_OR:   res = a | b;
            OP_AND:  res = a & b;
            OP_LSH:  res = a << sh;
            OP_RSH:  res = a >> sh;
            OP_NEG:  res = '0 - a;
            OP_MOD: begin
                res  = b_zero ? a : a % b;
                hold = b_zero;
            end
            OP_XOR:  res = a ^ b;
            OP_MOV:  res = b;
            OP_ARSH: res = $signed(a) >>> sh;
            default: res = a;
        endcase
    end
endmodule

// File: rtl/vm_alu_core.sv
// Width-class datapath: runs a full-width lane and a half-width lane side
// by side and selects by class. Assumes HALF equals the immediate width.
module vm_alu_core
    import vm_alu_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int IMMW = 32
) (
    input  logic [XLEN-1:0] dst_val,
    input  logic [XLEN-1:0] src_val,
    input  logic [IMMW-1:0] imm,
    input  logic            use_reg,
    input  logic            is32,
    input  alu_op_e         op,
    output logic [XLEN-1:0] result,
    output logic            hold
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] imm_ext, b_full, r_full;
    logic [HALF-1:0] b_half, r_half;
    logic            h_full, h_half;

    // Second-operand selection for each width.
    always_comb begin
        imm_ext = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
        b_full  = use_reg ? src_val : imm_ext;
        b_half  = use_reg ? src_val[HALF-1:0] : imm[HALF-1:0];
    end

    vm_alu_lane #(.W(XLEN)) i_lane_full (
        .a(dst_val), .b(b_full), .op(op), .res(r_full), .hold(h_full)
    );

    vm_alu_lane #(.W(HALF)) i_lane_half (
        .a(dst_val[HALF-1:0]), .b(b_half), .op(op), .res(r_half), .hold(h_half)
    );

    // Class select with zero extension of half-width results.
    always_comb begin
        result = is32 ? {{(XLEN-HALF){1'b0}}, r_half} : r_full;
        hold   = is32 ? h_half : h_full;
    end
endmodule

// File: rtl/vm_alu_stage.sv
// Top of the ALU execute stage: decoder, register file and datapath.
// One instruction per cycle, written back at the end of its issue cycle;
// trap and illegal flags are registered and pulse in the following cycle.
module vm_alu_stage
    import vm_alu_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int NREGS = 11,
    parameter int IDXW  = 4,
    parameter int IMMW  = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_valid,
    input  logic [7:0]      opcode,
    input  logic [IDXW-1:0] dst_sel,
    input  logic [IDXW-1:0] src_sel,
    input  logic [IMMW-1:0] imm32,
    input  logic [IDXW-1:0] peek_sel,
    output logic [XLEN-1:0] peek_data,
    output logic            trap_o,
    output logic            illegal_o
);
    dec_s            dec;
    logic [XLEN-1:0] dst_val, src_val, wr_data;
    logic            core_hold, wr_en, op_is32;

    vm_op_decode #(.NREGS(NREGS), .IDXW(IDXW)) i_dec (
        .valid(issue_valid), .opcode(opcode),
        .dst_sel(dst_sel), .src_sel(src_sel), .dec(dec)
    );

    vm_regfile #(.XLEN(XLEN), .NREGS(NREGS), .IDXW(IDXW)) i_rf (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en), .wa(dst_sel), .wd(wr_data),
        .ra_a(dst_sel), .rd_a(dst_val),
        .ra_b(src_sel), .rd_b(src_val),
        .ra_p(peek_sel), .rd_p(peek_data)
    );

    vm_alu_core #(.XLEN(XLEN), .IMMW(IMMW)) i_core (
        .dst_val(dst_val), .src_val(src_val), .imm(imm32),
        .use_reg(dec.use_reg), .is32(dec.is32), .op(dec.op),
        .result(wr_data), .hold(core_hold)
    );

    // Write enable: legal instruction and not a modulo by zero.
    always_comb begin
        wr_en    = dec.wr_ok && !core_hold;
        op_is32  = dec.is32;
    end

    // Registered status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_o    <= 1'b0;
            illegal_o <= 1'b0;
        end else begin
            trap_o    <= dec.trap;
            illegal_o <= dec.illegal;
        end
    end
endmodule

// File: rtl/vm_alu_checks.sv
// Property checker for vm_alu_stage, attached by bind below.
module vm_alu_checks #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            issue_valid,
    input logic [7:0]      opcode,
    input logic            trap_o,
    input logic            illegal_o,
    input logic            wr_en,
    input logic [XLEN-1:0] wr_data,
    input logic            op_is32
);
    localparam int HALF = XLEN / 2;

    assert_brk_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && opcode == 8'h8c) |=> (trap_o && !illegal_o));

    assert_brk_nowrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && opcode == 8'h8c) |-> !wr_en);

    assert_bad_class_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && opcode[2:0] != 3'h4 && opcode[2:0] != 3'h7) |=> illegal_o);

    assert_bad_class_nowrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && opcode[2:0] != 3'h4 && opcode[2:0] != 3'h7) |-> !wr_en);

    assert_zero_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op_is32) |-> (wr_data[XLEN-1:HALF] == '0));

    assert_idle_nowrite_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |-> !wr_en);

    assert_idle_noflag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |=> (!trap_o && !illegal_o));

    assert_flags_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_o && illegal_o));
endmodule

bind vm_alu_stage vm_alu_checks #(.XLEN(XLEN)) i_chk (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .opcode(opcode),
    .trap_o(trap_o), .illegal_o(illegal_o), .wr_en(wr_en),
    .wr_data(wr_data), .op_is32(op_is32)
);

// File: tb/test_vm_alu_stage.sv
// Directed bench for vm_alu_stage: one task per scenario.
module test_vm_alu_stage;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [7:0]  opcode = '0;
    logic [3:0]  dst_sel = '0, src_sel = '0, peek_sel = '0;
    logic [31:0] imm32 = '0;
    logic [63:0] peek_data;
    logic        trap_o, illegal_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    vm_alu_stage i_vm_alu_stage (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .opcode(opcode),
        .dst_sel(dst_sel), .src_sel(src_sel), .imm32(imm32),
        .peek_sel(peek_sel), .peek_data(peek_data),
        .trap_o(trap_o), .illegal_o(illegal_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present one instruction at a falling edge and keep it for one cycle.
    task automatic drive(input logic [7:0] op, input logic [3:0] d, input logic [3:0] s,
                         input logic [31:0] imm);
        @(negedge clk);
        issue_valid = 1'b1; opcode = op; dst_sel = d; src_sel = s; imm32 = imm;
    endtask

    task automatic idle();
        @(negedge clk);
        issue_valid = 1'b0;
    endtask

    task automatic issue(input logic [7:0] op, input logic [3:0] d, input logic [3:0] s,
                         input logic [31:0] imm);
        drive(op, d, s, imm);
        idle();
    endtask

    task automatic peek(input logic [3:0] idx, output logic [63:0] v);
        peek_sel = idx;
        #1;
        v = peek_data;
    endtask

    // Build a full 64-bit value in register r using r10 as scratch.
    task automatic load64(input logic [3:0] r, input logic [63:0] val);
        issue(8'hb7, r, 4'd0, val[63:32]);
        issue(8'h67, r, 4'd0, 32'd32);
        issue(8'hb4, 4'd10, 4'd0, val[31:0]);
        issue(8'h4f, r, 4'd10, 32'd0);
    endtask

    task automatic t_reset();
        logic [63:0] v;
        for (int i = 0; i < 11; i++) begin
            peek(4'(i), v);
            chk("R1 register cleared", v, 64'd0);
        end
        chk("R1 trap_o low", {63'd0, trap_o}, 64'd0);
        chk("R1 illegal_o low", {63'd0, illegal_o}, 64'd0);
    endtask

    task automatic t_alu64();
        logic [63:0] v;
        load64(4'd1, 64'h0123_4567_89ab_cdef);
        peek(4'd1, v); chk("R3 load via shift/or", v, 64'h0123_4567_89ab_cdef);
        issue(8'hb7, 4'd2, 4'd0, 32'h10);
        issue(8'h0f, 4'd1, 4'd2, 32'd0);
        peek(4'd1, v); chk("R3 add64 register", v, 64'h0123_4567_89ab_cdff);
        issue(8'hb7, 4'd3, 4'd0, 32'd5);
        issue(8'h07, 4'd3, 4'd0, 32'hffff_ffff);
        peek(4'd3, v); chk("R3 add64 sign-extended imm", v, 64'd4);
        issue(8'hb7, 4'd4, 4'd0, 32'h8000_0000);
        peek(4'd4, v); chk("R6 mov64 imm sign-extends", v, 64'hffff_ffff_8000_0000);
        issue(8'hbf, 4'd5, 4'd1, 32'd0);
        peek(4'd5, v); chk("R6 mov64 register", v, 64'h0123_4567_89ab_cdff);
        issue(8'hb7, 4'd6, 4'd0, 32'd1);
        issue(8'h67, 4'd6, 4'd0, 32'd32);
        issue(8'h27, 4'd6, 4'd0, 32'd3);
        peek(4'd6, v); chk("R3 mul64 imm", v, 64'h3_0000_0000);
        issue(8'h17, 4'd6, 4'd0, 32'd1);
        peek(4'd6, v); chk("R3 sub64 imm", v, 64'h2_ffff_ffff);
        issue(8'haf, 4'd6, 4'd4, 32'd0);
        peek(4'd6, v); chk("R2 xor64 register", v, 64'hffff_fffd_7fff_ffff);
        issue(8'h57, 4'd6, 4'd0, 32'h0000_ff00);
        peek(4'd6, v); chk("R2 and64 imm", v, 64'h0000_0000_0000_ff00);
    endtask

    task automatic t_alu32();
        logic [63:0] v;
        issue(8'hb7, 4'd5, 4'd0, 32'hffff_fffe);
        issue(8'h04, 4'd5, 4'd0, 32'd3);
        peek(4'd5, v); chk("R4 add32 wraps and zero-extends", v, 64'd1);
        issue(8'hbc, 4'd6, 4'd1, 32'd0);
        peek(4'd6, v); chk("R6 mov32 register", v, 64'h0000_0000_89ab_cdff);
        issue(8'hb4, 4'd7, 4'd0, 32'h8000_0000);
        peek(4'd7, v); chk("R6 mov32 imm zero-extends", v, 64'h0000_0000_8000_0000);
        issue(8'h84, 4'd6, 4'd3, 32'h1234);
        peek(4'd6, v); chk("R7 neg32", v, 64'h0000_0000_7654_3201);
        issue(8'hb7, 4'd8, 4'd0, 32'd5);
        issue(8'h87, 4'd8, 4'd1, 32'd9);
        peek(4'd8, v); chk("R7 neg64", v, 64'hffff_ffff_ffff_fffb);
        issue(8'hc4, 4'd7, 4'd0, 32'd4);
        peek(4'd7, v); chk("R5 arsh32 fills with bit 31", v, 64'h0000_0000_f800_0000);
        issue(8'hb7, 4'd9, 4'd0, 32'h8000_0000);
        issue(8'hc7, 4'd9, 4'd0, 32'd4);
        peek(4'd9, v); chk("R5 arsh64", v, 64'hffff_ffff_f800_0000);
        issue(8'hb7, 4'd2, 4'd0, 32'd1);
        issue(8'h67, 4'd2, 4'd0, 32'd65);
        peek(4'd2, v); chk("R5 lsh64 amount masked to 6 bits", v, 64'd2);
        issue(8'hb7, 4'd3, 4'd0, 32'd1);
        issue(8'h64, 4'd3, 4'd0, 32'd33);
        peek(4'd3, v); chk("R5 lsh32 amount masked to 5 bits", v, 64'd2);
        issue(8'hb7, 4'd4, 4'd0, 32'hffff_ffff);
        issue(8'h74, 4'd4, 4'd0, 32'd4);
        peek(4'd4, v); chk("R5 rsh32 logical on low half", v, 64'h0000_0000_0fff_ffff);
    endtask

    task automatic t_divmod();
        logic [63:0] v;
        issue(8'hb7, 4'd1, 4'd0, 32'd100);
        issue(8'h37, 4'd1, 4'd0, 32'd7);
        peek(4'd1, v); chk("R2 div64 imm", v, 64'd14);
        issue(8'hb7, 4'd2, 4'd0, 32'd100);
        issue(8'h97, 4'd2, 4'd0, 32'd7);
        peek(4'd2, v); chk("R2 mod64 imm", v, 64'd2);
        issue(8'hb7, 4'd3, 4'd0, 32'd55);
        issue(8'h37, 4'd3, 4'd0, 32'd0);
        peek(4'd3, v); chk("R8 div by zero gives 0", v, 64'd0);
        issue(8'hb7, 4'd4, 4'd0, 32'd55);
        issue(8'hb7, 4'd9, 4'd0, 32'd0);
        issue(8'h9f, 4'd4, 4'd9, 32'd0);
        peek(4'd4, v); chk("R8 mod64 by zero register keeps dst", v, 64'd55);
        issue(8'hb7, 4'd5, 4'd0, 32'hffff_fff0);
        issue(8'h94, 4'd5, 4'd0, 32'd0);
        peek(4'd5, v); chk("R8 mod32 by zero keeps upper half", v, 64'hffff_ffff_ffff_fff0);
        issue(8'hb7, 4'd6, 4'd0, 32'hffff_ffff);
        issue(8'h34, 4'd6, 4'd0, 32'd2);
        peek(4'd6, v); chk("R4 div32 unsigned", v, 64'h0000_0000_7fff_ffff);
    endtask

    task automatic t_breakpoint();
        logic [63:0] v;
        issue(8'hb7, 4'd1, 4'd0, 32'h1234);
        drive(8'h8c, 4'd1, 4'd2, 32'd7);
        idle();
        chk("R9 trap_o after breakpoint", {63'd0, trap_o}, 64'd1);
        chk("R9 no illegal on breakpoint", {63'd0, illegal_o}, 64'd0);
        peek(4'd1, v); chk("R9 breakpoint leaves dst", v, 64'h1234);
        @(negedge clk);
        chk("R9 trap_o lasts one cycle", {63'd0, trap_o}, 64'd0);
    endtask

    task automatic t_illegal(input logic [7:0] op, input logic [3:0] d, input logic [3:0] s,
                             input string what);
        logic [63:0] v;
        issue(8'hb7, 4'd1, 4'd0, 32'h55);
        drive(op, d, s, 32'd9);
        idle();
        chk({"R10 illegal_o for ", what}, {63'd0, illegal_o}, 64'd1);
        chk({"R10 no trap for ", what}, {63'd0, trap_o}, 64'd0);
        peek(4'd1, v); chk({"R10 r1 unchanged for ", what}, v, 64'h55);
        @(negedge clk);
        chk({"R10 illegal_o one cycle for ", what}, {63'd0, illegal_o}, 64'd0);
    endtask

    task automatic t_back_to_back();
        logic [63:0] v;
        issue(8'hb7, 4'd2, 4'd0, 32'h77);
        drive(8'hb7, 4'd1, 4'd0, 32'd7);
        drive(8'h0f, 4'd1, 4'd1, 32'd0);
        drive(8'h27, 4'd1, 4'd0, 32'd3);
        drive(8'h8c, 4'd2, 4'd1, 32'd0);
        drive(8'h07, 4'd1, 4'd0, 32'd1);
        chk("R11 trap_o during following issue", {63'd0, trap_o}, 64'd1);
        idle();
        peek(4'd1, v); chk("R11 dependent chain result", v, 64'd43);
        peek(4'd2, v); chk("R9 breakpoint in chain leaves r2", v, 64'h77);
    endtask

    task automatic t_no_issue();
        logic [63:0] v;
        issue(8'hb7, 4'd3, 4'd0, 32'd5);
        @(negedge clk);
        opcode = 8'hb7; dst_sel = 4'd3; imm32 = 32'd99;
        @(negedge clk);
        opcode = 8'h8c;
        @(negedge clk);
        opcode = 8'h05;
        @(negedge clk);
        chk("R12 no flags while idle", {62'd0, trap_o, illegal_o}, 64'd0);
        peek(4'd3, v); chk("R12 no write while idle", v, 64'd5);
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_alu64();
        t_alu32();
        t_divmod();
        t_breakpoint();
        t_illegal(8'h05, 4'd1, 4'd0, "class 5");
        t_illegal(8'hd7, 4'd1, 4'd0, "op 13");
        t_illegal(8'h8f, 4'd1, 4'd2, "0x8f");
        t_illegal(8'hb7, 4'd11, 4'd0, "dst 11");
        t_illegal(8'hbf, 4'd1, 4'd12, "src 12");
        t_back_to_back();
        t_no_issue();
        finished = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule